// File: doc/BRIEF.md
# Interrupt Status Set/Clear Unit

This unit keeps one interrupt status word. Bits get into it from two places. Internal sources pulse raise strobes, and each strobe carries a fixed bit mask. Software can also set bits by writing to one register offset. Software clears bits by writing a mask to a second offset, and reads the word back at a third offset. The register port is a plain single-cycle write strobe with an address and data. Reads are combinational on the address.

The unit signals pending requests in one of two ways, chosen by a mode input. In legacy mode it drives a level line. The line goes high on any raise that leaves the word non-zero. It goes low only when a clear empties the word. In message mode the level line is left alone. Each raise that leaves the word non-zero instead produces a one-cycle message pulse, and no clear ever produces one. Building the message and sending it on a bus is done outside this unit.

Top module: `irq_status_unit`

## Requirements
- R1: A write to offset 0x60 ORs the write data into the status word. The result is visible one cycle later.
- R2: A write to offset 0x64 clears every status bit that is 1 in the write data. A zero mask changes nothing.
- R3: `reg_rdata` shows the status word while `reg_addr` is 0x24, and shows zero at any other address.
- R4: In legacy mode (`msi_mode`=0), a raise that leaves the status non-zero drives `irq_level` high on the next cycle. This includes a set write of value zero.
- R5: In legacy mode, `irq_level` falls only when a clear leaves the status at zero. A clear that leaves bits pending does not change the line. It neither lowers it nor raises it.
- R6: In message mode (`msi_mode`=1), each raise that leaves the status non-zero gives `msg_pulse`=1 for exactly one cycle, the cycle after the raise, and `irq_level` holds its value.
- R7: A clear never produces a message pulse. Neither does a raise whose same-cycle clear leaves the status at zero.
- R8: Internal strobe `src_raise[0]` (computation done) sets status bit 0. `src_raise[1]` (transfer done) sets bit 8.
- R9: Raises that arrive in the same cycle are merged into one mask. A clear write in the same cycle as a strobe is applied after that strobe's bits are added.
- R10: While `rst_n` is low, the status word is zero and both `irq_level` and `msg_pulse` are low.
- R11: A raise that adds no new bit still counts as a raise. In message mode it pulses when other bits are already pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (8) | Register offset for read and write |
| reg_wdata | input | DATA_W (32) | Write data / bit mask |
| reg_rdata | output | DATA_W (32) | Read data (status at 0x24, else zero) |
| src_raise | input | N_SRC (2) | Internal raise strobes, one per source |
| msi_mode | input | 1 | 1 selects message pulses, 0 selects the level line |
| irq_level | output | 1 | Legacy interrupt level |
| msg_pulse | output | 1 | One-cycle message request |

## Verification
A software clear write can land in the same cycle as an internal raise strobe. Software sets can also coincide with strobes. The table drives a clear-all mask together with a strobe and expects an empty word and a low line. It also drives a set write together with the transfer strobe and expects the union of both masks. Message mode gets the same treatment: a strobe whose bit is cleared in the same cycle must produce no pulse.

// File: rtl/irq_su_pkg.sv
package irq_su_pkg;

   typedef enum logic [1:0] {
      OP_NONE = 2'd0,
      OP_SET  = 2'd1,
      OP_CLR  = 2'd2
   } reg_op_e;

endpackage

// File: rtl/irq_su_decode.sv
module irq_su_decode
   import irq_su_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter logic [ADDR_W-1:0] OFS_SET = 8'h60,
   parameter logic [ADDR_W-1:0] OFS_CLR = 8'h64
) (
   input  logic              wr,
   input  logic [ADDR_W-1:0] addr,
   output reg_op_e           op
);

   if (OFS_SET == OFS_CLR) begin : g_bad_ofs
      $error("irq_su_decode: set and clear offsets must differ");
   end

   always_comb begin
      op = OP_NONE;
      if (wr) begin
         if (addr == OFS_SET)      op = OP_SET;
         else if (addr == OFS_CLR) op = OP_CLR;
      end
   end

endmodule

// File: rtl/irq_su_merge.sv
module irq_su_merge #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned N_SRC   = 2,
   parameter int unsigned POS_W   = 8,
   parameter logic [N_SRC*POS_W-1:0] SRC_POS = {8'd8, 8'd0}
) (
   input  logic [N_SRC-1:0]  src_raise,
   input  logic              sw_set,
   input  logic [DATA_W-1:0] sw_mask,
   output logic              raise_evt,
   output logic [DATA_W-1:0] raise_mask
);

   logic [DATA_W-1:0] src_mask [N_SRC];

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      localparam int unsigned BITPOS = int'(SRC_POS[i*POS_W +: POS_W]);
      if (BITPOS >= DATA_W) begin : g_bad_pos
         $error("irq_su_merge: source bit position outside status word");
      end
      assign src_mask[i] = src_raise[i] ? (DATA_W'(1) << BITPOS) : '0;
   end

   always_comb begin
      raise_mask = sw_set ? sw_mask : '0;
      for (int k = 0; k < N_SRC; k++) begin
         raise_mask = raise_mask | src_mask[k];
      end
   end

   assign raise_evt = sw_set | (|src_raise);

endmodule

// File: rtl/irq_su_status.sv
module irq_su_status #(
   parameter int unsigned DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] raise_mask,
   input  logic              clr_evt,
   input  logic [DATA_W-1:0] clr_mask,
   output logic [DATA_W-1:0] status_q,
   output logic              next_nz
);

   logic [DATA_W-1:0] status_d;

   always_comb begin
      status_d = status_q | raise_mask;
      if (clr_evt) status_d = status_d & ~clr_mask;
   end

   assign next_nz = |status_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q <= '0;
      else        status_q <= status_d;
   end

endmodule

// File: rtl/irq_su_notify.sv
module irq_su_notify (
   input  logic clk,
   input  logic rst_n,
   input  logic msi_mode,
   input  logic raise_evt,
   input  logic clr_evt,
   input  logic next_nz,
   output logic irq_level,
   output logic msg_pulse
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_level <= 1'b0;
         msg_pulse <= 1'b0;
      end else begin
         msg_pulse <= msi_mode & raise_evt & next_nz;
         if (!msi_mode) begin
            if (raise_evt && next_nz)     irq_level <= 1'b1;
            else if (clr_evt && !next_nz) irq_level <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
   import irq_su_pkg::*;
#(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned N_SRC   = 2,
   parameter int unsigned POS_W   = 8,
   parameter logic [N_SRC*POS_W-1:0] SRC_POS = {8'd8, 8'd0},
   parameter logic [ADDR_W-1:0] OFS_STATUS = 8'h24,
   parameter logic [ADDR_W-1:0] OFS_SET    = 8'h60,
   parameter logic [ADDR_W-1:0] OFS_CLR    = 8'h64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [N_SRC-1:0]  src_raise,
   input  logic              msi_mode,
   output logic              irq_level,
   output logic              msg_pulse
);

   if (N_SRC < 1) begin : g_bad_nsrc
      $error("irq_status_unit: need at least one internal source");
   end

   reg_op_e           op;
   logic              raise_evt;
   logic              clr_evt;
   logic              next_nz;
   logic [DATA_W-1:0] raise_mask;
   logic [DATA_W-1:0] status_q;

   irq_su_decode #(
      .ADDR_W (ADDR_W),
      .OFS_SET(OFS_SET),
      .OFS_CLR(OFS_CLR)
   ) u_decode (
      .wr  (reg_wr),
      .addr(reg_addr),
      .op  (op)
   );

   irq_su_merge #(
      .DATA_W (DATA_W),
      .N_SRC  (N_SRC),
      .POS_W  (POS_W),
      .SRC_POS(SRC_POS)
   ) u_merge (
      .src_raise (src_raise),
      .sw_set    (op == OP_SET),
      .sw_mask   (reg_wdata),
      .raise_evt (raise_evt),
      .raise_mask(raise_mask)
   );

   assign clr_evt = (op == OP_CLR);

   irq_su_status #(
      .DATA_W(DATA_W)
   ) u_status (
      .clk       (clk),
      .rst_n     (rst_n),
      .raise_mask(raise_mask),
      .clr_evt   (clr_evt),
      .clr_mask  (reg_wdata),
      .status_q  (status_q),
      .next_nz   (next_nz)
   );

   irq_su_notify u_notify (
      .clk      (clk),
      .rst_n    (rst_n),
      .msi_mode (msi_mode),
      .raise_evt(raise_evt),
      .clr_evt  (clr_evt),
      .next_nz  (next_nz),
      .irq_level(irq_level),
      .msg_pulse(msg_pulse)
   );

   assign reg_rdata = (reg_addr == OFS_STATUS) ? status_q : '0;

endmodule

// File: rtl/irq_su_chk.sv
module irq_su_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned N_SRC  = 2,
   parameter logic [ADDR_W-1:0] OFS_SET = 8'h60,
   parameter logic [ADDR_W-1:0] OFS_CLR = 8'h64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic [ADDR_W-1:0] reg_addr,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [N_SRC-1:0]  src_raise,
   input logic              msi_mode,
   input logic [DATA_W-1:0] status,
   input logic              irq_level,
   input logic              msg_pulse
);

   AST_SET_ORS_BITS: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_SET) |=>
         ((status & $past(reg_wdata)) == $past(reg_wdata)));  // R1

   AST_CLR_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == OFS_CLR && src_raise == '0) |=> !msg_pulse);  // R7

   AST_MSG_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      msi_mode |=> $stable(irq_level));  // R6

   AST_PULSE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |-> (status != '0));  // R6

   AST_PULSE_NEEDS_MSG: assert property (@(posedge clk) disable iff (!rst_n)
      msg_pulse |-> $past(msi_mode));  // R6

   AST_LINE_FALL_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_level) |-> (status == '0));  // R5

   AST_LINE_RISE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_level) |-> (status != '0));  // R4

endmodule

bind irq_status_unit irq_su_chk #(
   .DATA_W (DATA_W),
   .ADDR_W (ADDR_W),
   .N_SRC  (N_SRC),
   .OFS_SET(OFS_SET),
   .OFS_CLR(OFS_CLR)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_addr (reg_addr),
   .reg_wdata(reg_wdata),
   .src_raise(src_raise),
   .msi_mode (msi_mode),
   .status   (status_q),
   .irq_level(irq_level),
   .msg_pulse(msg_pulse)
);

// File: tb/sim_irq_status_unit.sv
module sim_irq_status_unit;

   localparam int CLK_PERIOD = 10;
   localparam logic [7:0] A_STAT = 8'h24;
   localparam logic [7:0] A_SET  = 8'h60;
   localparam logic [7:0] A_CLR  = 8'h64;

   typedef struct packed {
      logic        msi;
      logic [1:0]  op;     // 0 none, 1 set, 2 clear
      logic [31:0] data;
      logic [1:0]  src;
      logic [31:0] st;
      logic        line;
      logic        pulse;
      logic [23:0] tag;
   } vec_t;

   localparam int NV = 16;
   localparam vec_t VEC [NV] = '{
      '{1'b0, 2'd1, 32'h0000_0005, 2'b00, 32'h0000_0005, 1'b1, 1'b0, "R4 "},
      '{1'b0, 2'd2, 32'h0000_0001, 2'b00, 32'h0000_0004, 1'b1, 1'b0, "R5 "},
      '{1'b0, 2'd2, 32'h0000_0004, 2'b00, 32'h0000_0000, 1'b0, 1'b0, "R2 "},
      '{1'b0, 2'd0, 32'h0000_0000, 2'b01, 32'h0000_0001, 1'b1, 1'b0, "R8 "},
      '{1'b0, 2'd1, 32'h0001_0000, 2'b10, 32'h0001_0101, 1'b1, 1'b0, "R9 "},
      '{1'b0, 2'd2, 32'hFFFF_FFFF, 2'b01, 32'h0000_0000, 1'b0, 1'b0, "R9 "},
      '{1'b1, 2'd1, 32'h0000_0002, 2'b00, 32'h0000_0002, 1'b0, 1'b1, "R6 "},
      '{1'b1, 2'd1, 32'h0000_0000, 2'b00, 32'h0000_0002, 1'b0, 1'b1, "R11"},
      '{1'b1, 2'd2, 32'h0000_0002, 2'b00, 32'h0000_0000, 1'b0, 1'b0, "R7 "},
      '{1'b1, 2'd0, 32'h0000_0000, 2'b10, 32'h0000_0100, 1'b0, 1'b1, "R8 "},
      '{1'b0, 2'd2, 32'h0000_0000, 2'b00, 32'h0000_0100, 1'b0, 1'b0, "R5 "},
      '{1'b0, 2'd1, 32'h0000_0000, 2'b00, 32'h0000_0100, 1'b1, 1'b0, "R4 "},
      '{1'b1, 2'd2, 32'h0000_0100, 2'b00, 32'h0000_0000, 1'b1, 1'b0, "R6 "},
      '{1'b0, 2'd2, 32'h0000_0000, 2'b00, 32'h0000_0000, 1'b0, 1'b0, "R5 "},
      '{1'b1, 2'd1, 32'h0000_0000, 2'b00, 32'h0000_0000, 1'b0, 1'b0, "R11"},
      '{1'b1, 2'd2, 32'h0000_0001, 2'b01, 32'h0000_0000, 1'b0, 1'b0, "R7 "}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [7:0]  reg_addr = A_STAT;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [1:0]  src_raise = '0;
   logic        msi_mode = 1'b0;
   logic        irq_level;
   logic        msg_pulse;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_status_unit u0 (
      .clk      (clk),
      .rst_n    (rst_n),
      .reg_wr   (reg_wr),
      .reg_addr (reg_addr),
      .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata),
      .src_raise(src_raise),
      .msi_mode (msi_mode),
      .irq_level(irq_level),
      .msg_pulse(msg_pulse)
   );

   task automatic check(input string what, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", what, got, exp);
      end
   endtask

   task automatic drive(input logic msi, input logic [1:0] op, input logic [31:0] d,
                        input logic [1:0] src);
      @(negedge clk);
      msi_mode  = msi;
      reg_wr    = (op != 2'd0);
      reg_addr  = (op == 2'd1) ? A_SET : (op == 2'd2) ? A_CLR : A_STAT;
      reg_wdata = d;
      src_raise = src;
      @(negedge clk);
      reg_wr    = 1'b0;
      reg_addr  = A_STAT;
      reg_wdata = '0;
      src_raise = '0;
      #1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #1;
      check("R10 status in reset", reg_rdata, 32'h0);
      check("R10 line in reset", {31'b0, irq_level}, 32'h0);
      check("R10 pulse in reset", {31'b0, msg_pulse}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         drive(VEC[i].msi, VEC[i].op, VEC[i].data, VEC[i].src);
         check($sformatf("%s vec%0d status", VEC[i].tag, i), reg_rdata, VEC[i].st);
         check($sformatf("%s vec%0d line", VEC[i].tag, i), {31'b0, irq_level}, {31'b0, VEC[i].line});
         check($sformatf("%s vec%0d pulse", VEC[i].tag, i), {31'b0, msg_pulse}, {31'b0, VEC[i].pulse});
      end

      // R3: read decode
      drive(1'b0, 2'd1, 32'h0000_0003, 2'b00);
      check("R1 set value read", reg_rdata, 32'h3);
      reg_addr = 8'h28;
      #1;
      check("R3 other offset reads zero", reg_rdata, 32'h0);
      reg_addr = A_STAT;

      // R6: pulse lasts exactly one cycle
      drive(1'b1, 2'd1, 32'h0000_0008, 2'b00);
      check("R6 pulse high", {31'b0, msg_pulse}, 32'h1);
      check("R6 line held in message mode", {31'b0, irq_level}, 32'h1);
      @(negedge clk);
      #1;
      check("R6 pulse one cycle only", {31'b0, msg_pulse}, 32'h0);
      check("R6 status kept", reg_rdata, 32'h0000_000B);

      // R10: reset in mid-operation
      @(negedge clk);
      rst_n = 1'b0;
      #1;
      check("R10 status after reset", reg_rdata, 32'h0);
      check("R10 line after reset", {31'b0, irq_level}, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule